// File: doc/BRIEF.md
# Transmit Queue Start-Threshold Controller

This block sits beside a transmit packet queue and decides when the packet at the head of that queue may start moving toward the MAC. It follows the writer through per-beat byte counts and end-of-packet flags, and the reader through the same kind of beats. From these it keeps a running byte fill and a count of packets whose final beat has been stored. The queue memory and the MAC framing are outside the block.

There are two release policies. In store-and-forward mode a packet starts only when its last beat is in the queue, and the threshold setting has no effect. In cut-through mode a packet starts once the bytes held for it exceed a level chosen by a 3-bit code from a non-linear table. A packet that is complete but shorter than that level is released as well. The queue capacity is set by a size code in 256-byte blocks. A full flag tells the writer to hold off, and any beat offered while the flag is high is discarded.

Top module: `tq_start_ctrl`

## Requirements
- R1: While reset is asserted and after reset is released, `tx_start` and `q_full` are both low until data is written.
- R2: In cut-through mode (`cfg_sf_en`=0), `tx_start` rises once the bytes stored for the head packet are strictly greater than the level selected by `cfg_thr_code`. The levels are: code 0 = 64, code 2 = 96, code 3 = 128, code 4 = 192, code 5 = 256, code 6 = 384, code 7 = 512 bytes. Holding exactly the level does not start the packet.
- R3: Threshold code 1 is reserved and behaves exactly like code 0 (64 bytes).
- R4: Once the head packet's end-of-packet beat has been stored, `tx_start` rises even if the packet is shorter than the threshold.
- R5: With `cfg_sf_en`=1, `tx_start` stays low until the head packet's end-of-packet beat is stored, however many bytes are held.
- R6: Capacity is (`cfg_size_code`+1)×256 bytes. `q_full` is high when the free space is smaller than one full beat (BEAT_BYTES, 16 by default). A write beat offered while `q_full` is high is discarded, including its end-of-packet flag.
- R7: Once raised, `tx_start` stays high until a read beat with `rd_eop` is taken. It is low in the following cycle, and the next packet is then evaluated afresh, so `tx_start` is low for at least one cycle between packets.
- R8: `q_full` reflects a write beat one clock edge after that beat is sampled. A `tx_start` rise caused by a write beat appears two clock edges after that beat is sampled.
- R9: Read beats offered while `tx_start` is low are ignored and leave the stored byte count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size_code | input | 7 | Queue size code; capacity = (code+1)×256 bytes |
| cfg_sf_en | input | 1 | 1 = store-and-forward, 0 = cut-through |
| cfg_thr_code | input | 3 | Cut-through threshold code |
| wr_valid | input | 1 | Write beat present |
| wr_bytes | input | 5 | Bytes in the write beat (0..16) |
| wr_eop | input | 1 | Write beat ends a packet |
| rd_valid | input | 1 | Read beat present |
| rd_bytes | input | 5 | Bytes in the read beat (0..16) |
| rd_eop | input | 1 | Read beat ends the head packet |
| tx_start | output | 1 | Head packet may be sent |
| q_full | output | 1 | Writer must stall |

## Verification
A write beat is sampled at a rising edge. The fill counter updates at that edge, so `q_full` can be read at the following falling edge. `tx_start` comes from a second register stage and is therefore checked one falling edge later, two edges after the write. A `tx_start` drop caused by a final read beat is checked at the first falling edge after that beat is taken. The bench drives every input on falling edges and reads outputs only at the falling edge where the value is due, so no result depends on process order at the active edge.

// File: rtl/tq_pkg.sv
package tq_pkg;

   localparam int THR_CODE_W = 3;
   localparam int THR_LVL_W  = 10;

   typedef enum logic {
      ST_HOLD = 1'b0,
      ST_SEND = 1'b1
   } start_st_e;

   // Non-linear cut-through table; reserved code 1 folds onto code 0.
   function automatic logic [THR_LVL_W-1:0] thr_level(input logic [THR_CODE_W-1:0] code);
      logic [THR_LVL_W-1:0] lvl;
      case (code)
         3'd2:    lvl = 10'd96;
         3'd3:    lvl = 10'd128;
         3'd4:    lvl = 10'd192;
         3'd5:    lvl = 10'd256;
         3'd6:    lvl = 10'd384;
         3'd7:    lvl = 10'd512;
         default: lvl = 10'd64;
      endcase
      return lvl;
   endfunction

endpackage

// File: rtl/tq_cfg_decode.sv
module tq_cfg_decode
   import tq_pkg::*;
#(
   parameter int SIZE_CODE_W = 7,
   parameter int BLOCK_BYTES = 256,
   parameter int BEAT_BYTES  = 16,
   parameter int CNT_W       = 16,
   parameter bit REG_OUT     = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SIZE_CODE_W-1:0] size_code,
   input  logic [THR_CODE_W-1:0]  thr_code,
   output logic [CNT_W-1:0]       thr_bytes,
   output logic [CNT_W-1:0]       cap_bytes,
   output logic [CNT_W-1:0]       full_mark
);

   localparam int BLK_SH = $clog2(BLOCK_BYTES);

   logic [CNT_W-1:0] thr_c;
   logic [CNT_W-1:0] cap_c;
   logic [CNT_W-1:0] mark_c;

   always_comb begin
      thr_c  = CNT_W'(thr_level(thr_code));
      cap_c  = (CNT_W'(size_code) + CNT_W'(1)) << BLK_SH;
      mark_c = cap_c - CNT_W'(BEAT_BYTES);
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               thr_bytes <= CNT_W'(64);
               cap_bytes <= CNT_W'(BLOCK_BYTES);
               full_mark <= CNT_W'(BLOCK_BYTES - BEAT_BYTES);
            end else begin
               thr_bytes <= thr_c;
               cap_bytes <= cap_c;
               full_mark <= mark_c;
            end
         end
      end else begin : g_comb
         assign thr_bytes = thr_c;
         assign cap_bytes = cap_c;
         assign full_mark = mark_c;
      end
   endgenerate

endmodule

// File: rtl/tq_fill_track.sv
module tq_fill_track #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 5,
   parameter int PKT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_acc,
   input  logic [BYTE_W-1:0] wr_bytes,
   input  logic              wr_eop,
   input  logic              rd_fire,
   input  logic [BYTE_W-1:0] rd_bytes,
   input  logic              rd_eop,
   output logic [CNT_W-1:0]  fill_q,
   output logic              head_done
);

   logic [PKT_W-1:0] eop_cnt_q;
   logic [CNT_W-1:0] add_b;
   logic [CNT_W-1:0] sub_b;
   logic             eop_in;
   logic             eop_out;

   always_comb begin
      add_b   = wr_acc  ? CNT_W'(wr_bytes) : '0;
      sub_b   = rd_fire ? CNT_W'(rd_bytes) : '0;
      eop_in  = wr_acc  & wr_eop;
      eop_out = rd_fire & rd_eop;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q    <= '0;
         eop_cnt_q <= '0;
      end else begin
         fill_q <= fill_q + add_b - sub_b;
         case ({eop_in, eop_out})
            2'b10:   eop_cnt_q <= eop_cnt_q + PKT_W'(1);
            2'b01:   eop_cnt_q <= eop_cnt_q - PKT_W'(1);
            default: eop_cnt_q <= eop_cnt_q;
         endcase
      end
   end

   // With no tail stored, every byte in the queue belongs to the head.
   assign head_done = (eop_cnt_q != '0);

endmodule

// File: rtl/tq_start_fsm.sv
module tq_start_fsm
   import tq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic release_ok,
   input  logic pkt_read_done,
   output logic tx_start
);

   start_st_e st_q;
   start_st_e st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_HOLD: if (release_ok)    st_d = ST_SEND;
         ST_SEND: if (pkt_read_done) st_d = ST_HOLD;
         default: st_d = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_HOLD;
      else        st_q <= st_d;
   end

   assign tx_start = (st_q == ST_SEND);

endmodule

// File: rtl/tq_start_ctrl.sv
module tq_start_ctrl
   import tq_pkg::*;
#(
   parameter int SIZE_CODE_W = 7,
   parameter int BLOCK_BYTES = 256,
   parameter int BEAT_BYTES  = 16,
   parameter bit REG_CFG     = 1'b0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [SIZE_CODE_W-1:0]            cfg_size_code,
   input  logic                              cfg_sf_en,
   input  logic [THR_CODE_W-1:0]             cfg_thr_code,
   input  logic                              wr_valid,
   input  logic [$clog2(BEAT_BYTES+1)-1:0]   wr_bytes,
   input  logic                              wr_eop,
   input  logic                              rd_valid,
   input  logic [$clog2(BEAT_BYTES+1)-1:0]   rd_bytes,
   input  logic                              rd_eop,
   output logic                              tx_start,
   output logic                              q_full
);

   localparam int MAX_CAP = (2 ** SIZE_CODE_W) * BLOCK_BYTES;
   localparam int CNT_W   = $clog2(MAX_CAP + 1);
   localparam int BYTE_W  = $clog2(BEAT_BYTES + 1);

   generate
      if ((BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_blk
         $error("BLOCK_BYTES must be a power of two");
      end
      if (BEAT_BYTES > BLOCK_BYTES) begin : g_bad_beat
         $error("BEAT_BYTES must not exceed BLOCK_BYTES");
      end
      if (CNT_W < THR_LVL_W) begin : g_bad_cnt
         $error("queue too small for the threshold table");
      end
   endgenerate

   logic [CNT_W-1:0] thr_bytes;
   logic [CNT_W-1:0] cap_bytes;
   logic [CNT_W-1:0] full_mark;
   logic [CNT_W-1:0] fill_q;
   logic             head_done;
   logic             wr_acc;
   logic             rd_fire;
   logic             over_thr;
   logic             release_ok;

   tq_cfg_decode #(
      .SIZE_CODE_W (SIZE_CODE_W),
      .BLOCK_BYTES (BLOCK_BYTES),
      .BEAT_BYTES  (BEAT_BYTES),
      .CNT_W       (CNT_W),
      .REG_OUT     (REG_CFG)
   ) i_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .size_code (cfg_size_code),
      .thr_code  (cfg_thr_code),
      .thr_bytes (thr_bytes),
      .cap_bytes (cap_bytes),
      .full_mark (full_mark)
   );

   assign q_full  = (fill_q > full_mark);
   assign wr_acc  = wr_valid & ~q_full;
   assign rd_fire = rd_valid & tx_start;

   tq_fill_track #(
      .CNT_W  (CNT_W),
      .BYTE_W (BYTE_W),
      .PKT_W  (CNT_W)
   ) i_fill (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_acc    (wr_acc),
      .wr_bytes  (wr_bytes),
      .wr_eop    (wr_eop),
      .rd_fire   (rd_fire),
      .rd_bytes  (rd_bytes),
      .rd_eop    (rd_eop),
      .fill_q    (fill_q),
      .head_done (head_done)
   );

   assign over_thr   = (fill_q > thr_bytes);
   assign release_ok = head_done | (~cfg_sf_en & over_thr);

   tq_start_fsm i_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .release_ok    (release_ok),
      .pkt_read_done (rd_fire & rd_eop),
      .tx_start      (tx_start)
   );

endmodule

// File: rtl/tq_start_ctrl_chk.sv
module tq_start_ctrl_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_start,
   input logic             wr_valid,
   input logic             rd_valid,
   input logic             rd_eop,
   input logic             cfg_sf_en,
   input logic [CNT_W-1:0] fill_q,
   input logic             head_done,
   input logic [CNT_W-1:0] cap_bytes
);

   // R7: a started packet stays released until its last beat is read
   a_r7_hold_until_eop: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start && !(rd_valid && rd_eop) |=> tx_start);

   // R7: the final read beat closes the packet for one cycle at least
   a_r7_drop_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start && rd_valid && rd_eop |=> !tx_start);

   // R4: a stored complete packet is always released
   a_r4_complete_release: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_start && head_done |=> tx_start);

   // R5: store-and-forward releases only complete packets
   a_r5_sf_needs_eop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_start) && cfg_sf_en |-> $past(head_done));

   // R6: the fill never passes the configured capacity
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= cap_bytes);

   // R9: without a release, reads cannot lower the fill
   a_r9_rd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_start && !wr_valid |=> fill_q >= $past(fill_q));

endmodule

bind tq_start_ctrl tq_start_ctrl_chk #(.CNT_W(CNT_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tx_start  (tx_start),
   .wr_valid  (wr_valid),
   .rd_valid  (rd_valid),
   .rd_eop    (rd_eop),
   .cfg_sf_en (cfg_sf_en),
   .fill_q    (fill_q),
   .head_done (head_done),
   .cap_bytes (cap_bytes)
);

// File: tb/test_tq_start_ctrl.sv
module test_tq_start_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] cfg_size_code = 7'd7;
   logic       cfg_sf_en = 1'b0;
   logic [2:0] cfg_thr_code = 3'd0;
   logic       wr_valid = 1'b0;
   logic [4:0] wr_bytes = '0;
   logic       wr_eop = 1'b0;
   logic       rd_valid = 1'b0;
   logic [4:0] rd_bytes = '0;
   logic       rd_eop = 1'b0;
   logic       tx_start;
   logic       q_full;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   tq_start_ctrl i_tq_start_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_size_code(cfg_size_code), .cfg_sf_en(cfg_sf_en), .cfg_thr_code(cfg_thr_code),
      .wr_valid(wr_valid), .wr_bytes(wr_bytes), .wr_eop(wr_eop),
      .rd_valid(rd_valid), .rd_bytes(rd_bytes), .rd_eop(rd_eop),
      .tx_start(tx_start), .q_full(q_full)
   );

   // {sf, thr_code, eop, expected tx_start, length}
   localparam int NV = 20;
   localparam logic [21:0] VEC [0:NV-1] = '{
      {1'b0, 3'd0, 1'b0, 1'b0, 16'd64},   // R2
      {1'b0, 3'd0, 1'b0, 1'b1, 16'd65},   // R2
      {1'b0, 3'd1, 1'b0, 1'b0, 16'd64},   // R3
      {1'b0, 3'd1, 1'b0, 1'b1, 16'd65},   // R3
      {1'b0, 3'd2, 1'b0, 1'b0, 16'd96},   // R2
      {1'b0, 3'd2, 1'b0, 1'b1, 16'd97},
      {1'b0, 3'd3, 1'b0, 1'b0, 16'd128},
      {1'b0, 3'd3, 1'b0, 1'b1, 16'd129},
      {1'b0, 3'd4, 1'b0, 1'b0, 16'd192},
      {1'b0, 3'd4, 1'b0, 1'b1, 16'd193},
      {1'b0, 3'd5, 1'b0, 1'b0, 16'd256},
      {1'b0, 3'd5, 1'b0, 1'b1, 16'd257},
      {1'b0, 3'd6, 1'b0, 1'b0, 16'd384},
      {1'b0, 3'd6, 1'b0, 1'b1, 16'd385},
      {1'b0, 3'd7, 1'b0, 1'b0, 16'd512},
      {1'b0, 3'd7, 1'b0, 1'b1, 16'd513},
      {1'b0, 3'd7, 1'b1, 1'b1, 16'd40},   // R4
      {1'b1, 3'd0, 1'b0, 1'b0, 16'd600},  // R5
      {1'b1, 3'd0, 1'b1, 1'b1, 16'd600},  // R5
      {1'b1, 3'd7, 1'b1, 1'b1, 16'd10}    // R5
   };

   task automatic check(input logic act, input logic exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset(input logic [6:0] sz, input logic sf, input logic [2:0] thr);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_size_code = sz;
      cfg_sf_en = sf;
      cfg_thr_code = thr;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wbeat(input int b, input logic eop);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_bytes = 5'(b);
      wr_eop = eop;
      @(negedge clk);
      wr_valid = 1'b0;
      wr_eop = 1'b0;
   endtask

   task automatic rbeat(input int b, input logic eop);
      @(negedge clk);
      rd_valid = 1'b1;
      rd_bytes = 5'(b);
      rd_eop = eop;
      @(negedge clk);
      rd_valid = 1'b0;
      rd_eop = 1'b0;
   endtask

   task automatic wpkt(input int len, input logic eop);
      int rem;
      rem = len;
      while (rem > 0) begin
         if (rem > 16) begin
            wbeat(16, 1'b0);
            rem -= 16;
         end else begin
            wbeat(rem, eop);
            rem = 0;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: outputs during and after reset
      @(negedge clk);
      check(tx_start, 1'b0, "R1 tx_start in reset");
      check(q_full, 1'b0, "R1 q_full in reset");
      do_reset(7'd7, 1'b0, 3'd0);
      repeat (2) @(negedge clk);
      check(tx_start, 1'b0, "R1 tx_start after reset");
      check(q_full, 1'b0, "R1 q_full after reset");

      // Table: threshold table, reserved code, complete and store-forward release
      for (int i = 0; i < NV; i++) begin
         do_reset(7'd7, VEC[i][21], VEC[i][20:18]);
         wpkt(int'(VEC[i][15:0]), VEC[i][17]);
         repeat (2) @(negedge clk);
         check(tx_start, VEC[i][16], $sformatf("R2/R3/R4/R5 vector %0d", i));
      end

      // R8: latency from the write beat
      do_reset(7'd7, 1'b0, 3'd0);
      wbeat(16, 1'b1);
      check(tx_start, 1'b0, "R8 not yet one edge after write");
      @(negedge clk);
      check(tx_start, 1'b1, "R8 raised two edges after write");

      // R7: hold until last read beat, then re-evaluate
      do_reset(7'd7, 1'b0, 3'd7);
      wpkt(32, 1'b1);
      wpkt(20, 1'b1);
      @(negedge clk);
      check(tx_start, 1'b1, "R7 first packet released");
      rbeat(16, 1'b0);
      check(tx_start, 1'b1, "R7 held mid packet");
      rbeat(16, 1'b1);
      check(tx_start, 1'b0, "R7 low after last beat");
      @(negedge clk);
      check(tx_start, 1'b1, "R7 next complete packet released");
      rbeat(16, 1'b0);
      rbeat(4, 1'b1);
      check(tx_start, 1'b0, "R7 low after second packet");
      repeat (2) @(negedge clk);
      check(tx_start, 1'b0, "R7 stays low on empty queue");

      // R6: capacity 256, full at 256 bytes, dropped beat while full
      do_reset(7'd0, 1'b1, 3'd0);
      for (int k = 0; k < 15; k++) wbeat(16, 1'b0);
      check(q_full, 1'b0, "R6 not full at 240");
      wbeat(16, 1'b0);
      check(q_full, 1'b1, "R6 full at 256 (R8 one edge)");
      wbeat(16, 1'b1);
      repeat (3) @(negedge clk);
      check(tx_start, 1'b0, "R6 eop beat dropped while full");
      // R9: reads ignored while not released
      rbeat(16, 1'b1);
      check(q_full, 1'b1, "R9 fill unchanged by ignored read");
      @(negedge clk);
      check(tx_start, 1'b0, "R9 no release after ignored read");

      // R6: capacity 512 with size code 1
      do_reset(7'd1, 1'b1, 3'd0);
      for (int k = 0; k < 31; k++) wbeat(16, 1'b0);
      check(q_full, 1'b0, "R6 not full at 496");
      wbeat(16, 1'b0);
      check(q_full, 1'b1, "R6 full at 512");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule